// File: doc/BRIEF.md
# Flash Write Status Bit Generator

This block stands in for the device side of a parallel NOR flash while an internal program or erase is running. The command decoder tells it what operation is under way, which sector is being erased and how many write-enable pulses have been counted. The array supplies the true stored byte. On every read the block returns that byte with status bits put in place of some of its bits, and it drives an active-low busy flag.

Bit 7 carries a polarity flag: complemented data while a program runs, and 0 while an erase runs. Bit 6 alternates on each completed read while work is in progress. Bit 2 alternates only while erase work concerns the addressed sector, so software can tell an active erase from a suspended one.

The two toggle bits live in flip-flops. They change only at the clock edge where a read strobe is high. The outputs are combinational from the current inputs and those two flip-flops.

Top module: `flash_status_gen`

## Requirements
- R1: After reset both toggle flip-flops are 0, so the first status read of an active erase returns bit 6 = 0 and bit 2 = 0.
- R2: The operation code is 3 bits: 0 idle, 1 program, 2 erase, 3 erase-suspended, 4 program during erase-suspend. Codes 5 to 7 behave as idle. A read targets the suspended sector when `rd_sector` equals `ers_sector`.
- R3: Status is valid for codes 1 and 4 once `we_count` >= 4, and for code 2 once `we_count` >= 6. Before that the read returns the true byte with `busy_n` = 1, and no toggle flip-flop changes.
- R4: During a valid program (code 1), bit 7 is the complement of true bit 7, bit 6 is the bit-6 toggle state and `busy_n` = 0.
- R5: During a valid program (code 1), bit 2 shows the bit-2 toggle state, and that state does not change on reads.
- R6: During a valid erase (code 2), bit 7 = 0, bit 6 and bit 2 show their toggle states, and `busy_n` = 0.
- R7: The bit-6 toggle state inverts on every clock edge with `rd_strobe` high during a valid code 1, 2 or 4. The bit-2 toggle state inverts on such an edge during a valid code 2, or during code 3 when the suspended sector is read. Without a strobe neither state changes.
- R8: In code 3, a read of the suspended sector returns bit 7 = 1 and bit 6 = 1, with bit 2 as the bit-2 toggle state and `busy_n` = 1.
- R9: In code 3, a read of any other sector returns the true byte with `busy_n` = 1, and neither toggle state changes.
- R10: In code 4 (when valid), bit 7 is the complement of true bit 7, bit 6 is the bit-6 toggle state, bit 2 is the true bit 2 and `busy_n` = 0.
- R11: In idle, including after completion, the true byte is returned unchanged with `busy_n` = 1. Bits 5, 4, 3, 1 and 0 are always the true data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_state | input | 3 | Operation code (R2) |
| rd_strobe | input | 1 | High for one cycle per completed read |
| rd_sector | input | SECTOR_W | Sector field of the read address |
| ers_sector | input | SECTOR_W | Sector under erase or suspend |
| true_data | input | 8 | Byte stored in the array at the read address |
| we_count | input | CNT_W | Write-enable pulses seen in the command |
| rd_data | output | 8 | Byte returned to the bus |
| busy_n | output | 1 | Low while a program or erase is in progress |

## Verification
A toggle flip-flop that inverts at the wrong time shows up on the very next status read: bit 6 or bit 2 repeats a value where it should alternate, or alternates where it should hold. Any error in the pulse threshold or the sector match is visible in the same cycle as the read, through bit 7 and `busy_n`. For that reason the bench follows each read that should leave the toggle states alone with a status read that exposes them.

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
  parameter int SECTOR_W   = 8,
  parameter int CNT_W      = 4,
  parameter int PGM_PULSES = 4,
  parameter int ERS_PULSES = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          op_state,
  input  logic                rd_strobe,
  input  logic [SECTOR_W-1:0] rd_sector,
  input  logic [SECTOR_W-1:0] ers_sector,
  input  logic [7:0]          true_data,
  input  logic [CNT_W-1:0]    we_count,
  output logic [7:0]          rd_data,
  output logic                busy_n
);

  localparam logic [2:0] OP_PGM   = 3'd1;
  localparam logic [2:0] OP_ERS   = 3'd2;
  localparam logic [2:0] OP_SUSP  = 3'd3;
  localparam logic [2:0] OP_SPGM  = 3'd4;
  localparam logic [CNT_W-1:0] PGM_MIN = CNT_W'(PGM_PULSES);
  localparam logic [CNT_W-1:0] ERS_MIN = CNT_W'(ERS_PULSES);

  logic tog6, tog2;

  wire pgm_go   = (op_state == OP_PGM)  && (we_count >= PGM_MIN);
  wire spgm_go  = (op_state == OP_SPGM) && (we_count >= PGM_MIN);
  wire ers_go   = (op_state == OP_ERS)  && (we_count >= ERS_MIN);
  wire susp_hit = (op_state == OP_SUSP) && (rd_sector == ers_sector);

  wire flip6 = rd_strobe && (pgm_go || spgm_go || ers_go);
  wire flip2 = rd_strobe && (ers_go || susp_hit);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tog6 <= 1'b0;
      tog2 <= 1'b0;
    end else begin
      if (flip6) tog6 <= ~tog6;
      if (flip2) tog2 <= ~tog2;
    end

  always_comb begin
    rd_data = true_data;
    busy_n  = 1'b1;
    if (pgm_go) begin
      rd_data[7] = ~true_data[7];
      rd_data[6] = tog6;
      rd_data[2] = tog2;
      busy_n     = 1'b0;
    end else if (spgm_go) begin
      rd_data[7] = ~true_data[7];
      rd_data[6] = tog6;
      busy_n     = 1'b0;
    end else if (ers_go) begin
      rd_data[7] = 1'b0;
      rd_data[6] = tog6;
      rd_data[2] = tog2;
      busy_n     = 1'b0;
    end else if (susp_hit) begin
      rd_data[7] = 1'b1;
      rd_data[6] = 1'b1;
      rd_data[2] = tog2;
    end
  end

  a_r7_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> $stable(tog6) && $stable(tog2));

  a_r5_prog_bit2_still: assert property (@(posedge clk) disable iff (!rst_n)
    (op_state == OP_PGM) |=> $stable(tog2));

  a_r4_prog_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (op_state == OP_PGM && we_count >= PGM_MIN) |-> !busy_n && rd_data[7] != true_data[7]);

  a_r8_susp_sector_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (op_state == OP_SUSP && rd_sector == ers_sector) |-> busy_n && rd_data[7:6] == 2'b11);

  a_r9_other_sector_data: assert property (@(posedge clk) disable iff (!rst_n)
    (op_state == OP_SUSP && rd_sector != ers_sector) |-> busy_n && rd_data == true_data);

  a_r6_erase_bit7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_state == OP_ERS && we_count >= ERS_MIN) |-> !busy_n && !rd_data[7]);

  a_r11_low_bits_pass: assert property (@(posedge clk) disable iff (!rst_n)
    {rd_data[5:3], rd_data[1:0]} == {true_data[5:3], true_data[1:0]});

endmodule

// File: tb/flash_status_gen_tb_top.sv
`timescale 1ns/1ps
module flash_status_gen_tb_top;
  localparam int SW = 8;
  localparam int CW = 4;

  logic clk = 0, rst_n = 0;
  logic [2:0] op_state = 0;
  logic rd_strobe = 0;
  logic [SW-1:0] rd_sector = 0, ers_sector = 0;
  logic [7:0] true_data = 0;
  logic [CW-1:0] we_count = 0;
  logic [7:0] rd_data;
  logic busy_n;

  int checks = 0, errors = 0;
  bit done = 0;
  bit m6 = 0, m2 = 0;

  always #2 clk = ~clk;

  flash_status_gen #(.SECTOR_W(SW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_state(op_state), .rd_strobe(rd_strobe),
    .rd_sector(rd_sector), .ers_sector(ers_sector), .true_data(true_data),
    .we_count(we_count), .rd_data(rd_data), .busy_n(busy_n));

  function automatic logic [8:0] expect_out(logic [2:0] op, bit hit, logic [7:0] d,
                                            int cnt, bit t6, bit t2);
    logic [7:0] r = d;
    logic b = 1'b1;
    if (op == 1 && cnt >= 4) begin r[7] = ~d[7]; r[6] = t6; r[2] = t2; b = 0; end
    else if (op == 4 && cnt >= 4) begin r[7] = ~d[7]; r[6] = t6; b = 0; end
    else if (op == 2 && cnt >= 6) begin r[7] = 0; r[6] = t6; r[2] = t2; b = 0; end
    else if (op == 3 && hit) begin r[7] = 1; r[6] = 1; r[2] = t2; end
    return {b, r};
  endfunction

  task automatic do_read(input logic [2:0] op, input logic [SW-1:0] rs, input logic [SW-1:0] es,
                         input logic [7:0] d, input int cnt, input bit strobe, input string tag);
    logic [8:0] exp;
    bit hit, act;
    @(negedge clk);
    op_state = op; rd_sector = rs; ers_sector = es; true_data = d;
    we_count = CW'(cnt); rd_strobe = strobe;
    #1;
    hit = (rs == es);
    exp = expect_out(op, hit, d, cnt, m6, m2);
    checks++;
    if ({busy_n, rd_data} !== exp) begin
      errors++;
      $display("FAIL %s: op=%0d got busy_n=%b data=%h expected busy_n=%b data=%h",
               tag, op, busy_n, rd_data, exp[8], exp[7:0]);
    end
    @(posedge clk);
    act = ((op == 1 || op == 4) && cnt >= 4) || (op == 2 && cnt >= 6);
    if (strobe) begin
      if (act) m6 = ~m6;
      if ((op == 2 && cnt >= 6) || (op == 3 && hit)) m2 = ~m2;
    end
    #1 rd_strobe = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    do_read(3'd2, 8'h10, 8'h10, 8'hFF, 6, 1, "R1 reset toggle state via erase read");
    do_read(3'd2, 8'h10, 8'h10, 8'hFF, 6, 1, "R7 R6 erase toggles flip");
    do_read(3'd1, 8'h01, 8'h02, 8'h80, 4, 1, "R4 program complement bit7");
    do_read(3'd1, 8'h01, 8'h02, 8'h00, 4, 1, "R5 program bit2 holds");
    do_read(3'd1, 8'h01, 8'h02, 8'h5A, 3, 1, "R3 program below threshold");
    do_read(3'd2, 8'h01, 8'h02, 8'h5A, 5, 1, "R3 erase below threshold");
    do_read(3'd2, 8'h01, 8'h02, 8'h5A, 6, 0, "R3 no toggle after early reads");
    do_read(3'd3, 8'h22, 8'h22, 8'h00, 0, 1, "R8 suspended sector read");
    do_read(3'd3, 8'h23, 8'h22, 8'hC3, 0, 1, "R9 other sector in suspend");
    do_read(3'd3, 8'h22, 8'h22, 8'h00, 0, 0, "R9 toggle unchanged after other sector");
    do_read(3'd4, 8'h05, 8'h22, 8'h04, 7, 1, "R10 program in suspend");
    do_read(3'd4, 8'h05, 8'h22, 8'h00, 4, 0, "R10 bit2 is true data");
    do_read(3'd0, 8'h05, 8'h05, 8'hA5, 9, 1, "R11 idle pass through");
    do_read(3'd6, 8'h05, 8'h05, 8'hA5, 9, 1, "R2 unused code as idle");
    do_read(3'd2, 8'h05, 8'h05, 8'hA5, 6, 0, "R7 no strobe no toggle");
    do_read(3'd2, 8'h05, 8'h05, 8'hA5, 6, 0, "R7 still no toggle");
    for (int i = 0; i < 400; i++) begin
      logic [2:0] op = 3'($urandom_range(0, 7));
      logic [SW-1:0] es = SW'($urandom_range(0, 3));
      logic [SW-1:0] rs = SW'($urandom_range(0, 3));
      do_read(op, rs, es, 8'($urandom), $urandom_range(0, 15), bit'($urandom_range(0, 1)),
              "R2 R7 random mix");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, got no end expected end");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule